// File: doc/BRIEF.md
# Calendar Alarm and Periodic Interrupt Unit

This block sits next to a BCD calendar counter. It decides when that counter's time should interrupt the processor. Once per second the counter pulses an update strobe. In the same cycle it presents the advanced time as six bytes (seconds, minutes, hour with meridiem, day of month, month, year) and four flags that say which of seconds, minutes, hours and days moved in that step. The unit compares the time with six programmed alarm bytes. It records which fields moved as event status bits, and it raises one shared interrupt line for two sources: an alarm match and a periodic tick.

Software reaches the unit through a small register port. Select codes 0 to 5 hold the alarm bytes. Select code 6 holds the enable register, and select code 7 holds the status register, whose alarm bit is cleared by writing 1 to it. Two state machines carry the sticky parts. The alarm machine has the states AL_IDLE and AL_FIRED. It goes AL_IDLE to AL_FIRED on an update whose time equals all six alarm bytes. It goes AL_FIRED to AL_IDLE on a status write with bit 6 set. If both happen in the same cycle, the match wins.

The periodic machine has the states PR_OFF, PR_ARMED and PR_PEND. It enters PR_OFF from any state while the timer enable is 0. It goes PR_OFF to PR_ARMED once the timer enable is 1. It goes from PR_OFF or PR_ARMED to PR_PEND on an update whose selected field moved, and an update of that kind also keeps it in PR_PEND. It goes PR_PEND to PR_ARMED on a status write that sets the event bit of the selected period. Every update, write and enable change takes effect at the clock edge where it is presented, and reads are combinational.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, the alarm bytes, the enable register and the status register read 0, and irq is low.
- R2: Select codes 0 to 5 store and read back the alarm bytes in the order seconds, minutes, hour (bit 7 = PM), day, month, year. Select code 6 stores and reads back enable bits 3:0: bit 3 is alarm enable, bit 2 is timer enable, and bits 1:0 are the period select. Select code 7 reads the status register.
- R3: Status bit 6 (alarm) is set at the edge of an update strobe when all six bytes of cur_time equal the six alarm bytes. If any byte differs, including the meridiem bit alone, the bit is not set.
- R4: Once set, status bit 6 stays set until a status write has bit 6 at 1. A status write with bit 6 at 0 leaves it unchanged.
- R5: While timer enable is 1, every update loads status bits 5, 4, 3 and 2 from inc_flags bits 3 (day), 2 (hour), 1 (minute) and 0 (second), whatever period is selected. Between updates these bits hold.
- R6: While the registered timer enable is 0, status bits 5:2 and the periodic pending flag read 0 from the next cycle on.
- R7: The periodic pending flag is set only by an update whose inc_flags bit, indexed by the period select (0 second, 1 minute, 2 hour, 3 day), is 1.
- R8: The pending flag clears on a status write that has a 1 in the event bit of the selected period (bit 2 plus the period select). A 1 in any other event bit leaves the flag set.
- R9: irq is high when (status bit 6 AND alarm enable) or the pending flag is high. An alarm status set while alarm enable is 0 raises irq only once the enable is written to 1.
- R10: When a setting event and a clearing write land in the same cycle, the setting event wins, for both the alarm bit and the pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_stb | input | 1 | One-cycle pulse marking a calendar update |
| inc_flags | input | 4 | Fields that moved in this update: bit 0 sec, 1 min, 2 hour, 3 day |
| cur_time | input | 48 | Advanced time, one BCD byte per field, seconds in bits 7:0 through year in bits 47:40 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench builds the unit with its default parameters: 8-bit fields, six compared fields and four event flags. These values make the full select space, codes 0 to 7, reachable. They also make every period select and every event bit reachable. The directed stimulus aims at the edges of that space: a mismatch in the meridiem bit alone, a mismatch in the day byte alone, a midnight rollover that moves all four fields, and a clearing write on an event bit that is not the selected one. It also lands setting and clearing events in the same cycle for both state machines.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    typedef enum logic [0:0] {
        AL_IDLE  = 1'b0,
        AL_FIRED = 1'b1
    } al_state_t;

    typedef enum logic [1:0] {
        PR_OFF   = 2'd0,
        PR_ARMED = 2'd1,
        PR_PEND  = 2'd2
    } pr_state_t;

    // status layout: event bits start here, alarm bit sits just above them
    localparam int EV_LSB = 2;

endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int FW = 8,
    parameter int NF = 6
) (
    input  logic [FW*NF-1:0] cur,
    input  logic [FW*NF-1:0] alm,
    output logic             hit
);

    logic [NF-1:0] eq;

    for (genvar gi = 0; gi < NF; gi++) begin : g_eq
        assign eq[gi] = (cur[gi*FW +: FW] == alm[gi*FW +: FW]);
    end

    assign hit = &eq;

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_irq_pkg::*;
#(
    parameter int FW   = 8,
    parameter int NF   = 6,
    parameter int SELW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SELW-1:0]  wr_sel,
    input  logic [FW-1:0]    wr_data,
    input  logic             clr_req,
    input  logic             upd_stb,
    input  logic [FW*NF-1:0] cur_time,
    output logic [FW*NF-1:0] alm_regs,
    output logic             al_st
);

    al_state_t state_q, state_d;
    logic      hit;

    for (genvar gi = 0; gi < NF; gi++) begin : g_fld
        logic [FW-1:0] fld_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                fld_q <= '0;
            else if (wr_en && wr_sel == SELW'(gi))
                fld_q <= wr_data;
        end
        assign alm_regs[gi*FW +: FW] = fld_q;
    end

    rtc_alarm_cmp #(.FW(FW), .NF(NF)) cmp_i (
        .cur (cur_time),
        .alm (alm_regs),
        .hit (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AL_IDLE:  if (upd_stb && hit) state_d = AL_FIRED;
            AL_FIRED: if (!(upd_stb && hit) && clr_req) state_d = AL_IDLE;
            default:  state_d = AL_IDLE;
        endcase
    end

    always_comb begin
        al_st = (state_q == AL_FIRED);
    end

endmodule

// File: rtl/rtc_period_unit.sv
module rtc_period_unit
    import rtc_irq_pkg::*;
#(
    parameter int NEV = 4,
    parameter int PSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tmr_en,
    input  logic [PSW-1:0] psel,
    input  logic           upd_stb,
    input  logic [NEV-1:0] inc_flags,
    input  logic [NEV-1:0] clr_bits,
    output logic [NEV-1:0] ev_q,
    output logic           pend
);

    pr_state_t state_q, state_d;
    logic      sel_inc;
    logic      sel_clr;

    assign sel_inc = inc_flags[psel];
    assign sel_clr = clr_bits[psel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ev_q <= '0;
        else if (!tmr_en)  ev_q <= '0;
        else if (upd_stb)  ev_q <= inc_flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PR_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!tmr_en) begin
            state_d = PR_OFF;
        end else if (upd_stb && sel_inc) begin
            state_d = PR_PEND;
        end else begin
            unique case (state_q)
                PR_OFF:   state_d = PR_ARMED;
                PR_ARMED: state_d = PR_ARMED;
                PR_PEND:  if (sel_clr) state_d = PR_ARMED;
                default:  state_d = PR_OFF;
            endcase
        end
    end

    always_comb begin
        pend = (state_q == PR_PEND);
    end

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_irq_pkg::*;
#(
    parameter int FW  = 8,
    parameter int NF  = 6,
    parameter int NEV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_stb,
    input  logic [NEV-1:0]   inc_flags,
    input  logic [FW*NF-1:0] cur_time,
    input  logic             wr_en,
    input  logic [$clog2(NF+2)-1:0] wr_sel,
    input  logic [FW-1:0]    wr_data,
    input  logic [$clog2(NF+2)-1:0] rd_sel,
    output logic [FW-1:0]    rd_data,
    output logic             irq
);

    localparam int SELW   = $clog2(NF + 2);
    localparam int PSW    = $clog2(NEV);
    localparam int ENW    = PSW + 2;
    localparam int AL_BIT = EV_LSB + NEV;
    localparam logic [SELW-1:0] SEL_EN = SELW'(NF);
    localparam logic [SELW-1:0] SEL_ST = SELW'(NF + 1);

    logic [ENW-1:0]   en_q;
    logic [FW*NF-1:0] alm_regs;
    logic             al_st;
    logic [NEV-1:0]   ev_q;
    logic             pend;
    logic             st_wr;
    logic [FW-1:0]    st_vec;

    assign st_wr = wr_en && (wr_sel == SEL_ST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en && wr_sel == SEL_EN)
            en_q <= wr_data[ENW-1:0];
    end

    rtc_alarm_unit #(.FW(FW), .NF(NF), .SELW(SELW)) alarm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .clr_req  (st_wr && wr_data[AL_BIT]),
        .upd_stb  (upd_stb),
        .cur_time (cur_time),
        .alm_regs (alm_regs),
        .al_st    (al_st)
    );

    rtc_period_unit #(.NEV(NEV), .PSW(PSW)) period_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmr_en    (en_q[PSW]),
        .psel      (en_q[PSW-1:0]),
        .upd_stb   (upd_stb),
        .inc_flags (inc_flags),
        .clr_bits  (st_wr ? wr_data[EV_LSB +: NEV] : '0),
        .ev_q      (ev_q),
        .pend      (pend)
    );

    always_comb begin
        st_vec                 = '0;
        st_vec[AL_BIT]         = al_st;
        st_vec[EV_LSB +: NEV]  = ev_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NF; i++) begin
            if (rd_sel == SELW'(i)) rd_data = alm_regs[i*FW +: FW];
        end
        if (rd_sel == SEL_EN) rd_data = FW'(en_q);
        if (rd_sel == SEL_ST) rd_data = st_vec;
    end

    assign irq = (al_st && en_q[PSW+1]) || pend;

endmodule

// File: rtl/rtc_irq_unit_chk.sv
module rtc_irq_unit_chk #(
    parameter int FW  = 8,
    parameter int NF  = 6,
    parameter int NEV = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    upd_stb,
    input logic                    wr_en,
    input logic [$clog2(NF+2)-1:0] wr_sel,
    input logic [FW-1:0]           wr_data,
    input logic                    al_st,
    input logic [NEV-1:0]          ev_q,
    input logic                    pend,
    input logic [$clog2(NEV)+1:0]  en_q
);

    localparam int SELW   = $clog2(NF + 2);
    localparam int PSW    = $clog2(NEV);
    localparam int AL_BIT = 2 + NEV;
    localparam logic [SELW-1:0] SEL_ST = SELW'(NF + 1);

    assert_alarm_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (al_st && !(wr_en && wr_sel == SEL_ST && wr_data[AL_BIT])) |=> al_st);

    assert_alarm_on_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(al_st) |-> $past(upd_stb));

    assert_events_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[PSW] |=> (ev_q == '0 && !pend));

    assert_events_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[PSW] && !upd_stb) |=> $stable(ev_q));

    assert_pend_on_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(upd_stb));

endmodule

bind rtc_irq_unit rtc_irq_unit_chk #(.FW(FW), .NF(NF), .NEV(NEV)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_stb (upd_stb),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .al_st   (al_st),
    .ev_q    (ev_q),
    .pend    (pend),
    .en_q    (en_q)
);

// File: tb/rtc_irq_unit_tb_top.sv
`timescale 1ns/100ps
module rtc_irq_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_stb = 1'b0;
    logic [3:0]  inc_flags = '0;
    logic [47:0] cur_time = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rtc_irq_unit dut_i (
        .clk (clk), .rst_n (rst_n), .upd_stb (upd_stb), .inc_flags (inc_flags),
        .cur_time (cur_time), .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
        .rd_sel (rd_sel), .rd_data (rd_data), .irq (irq)
    );

    // behavioural reference model
    logic [7:0] m_alm [6];
    logic [3:0] m_en;
    logic [3:0] m_ev;
    logic       m_al;
    logic       m_pend;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) m_alm[i] = 8'h00;
            m_en = 0; m_ev = 0; m_al = 0; m_pend = 0;
        end else begin
            bit match;
            bit n_al, n_pend;
            logic [3:0] n_ev;
            match = 1;
            for (int i = 0; i < 6; i++)
                if (cur_time[i*8 +: 8] != m_alm[i]) match = 0;
            n_al = m_al;
            if (upd_stb && match) n_al = 1;
            else if (wr_en && wr_sel == 7 && wr_data[6]) n_al = 0;
            n_ev = m_ev;
            n_pend = m_pend;
            if (!m_en[2]) begin
                n_ev = 0; n_pend = 0;
            end else begin
                if (upd_stb) n_ev = inc_flags;
                if (upd_stb && inc_flags[m_en[1:0]]) n_pend = 1;
                else if (wr_en && wr_sel == 7 && wr_data[2 + m_en[1:0]]) n_pend = 0;
            end
            if (wr_en && wr_sel < 6) m_alm[wr_sel] = wr_data;
            if (wr_en && wr_sel == 6) m_en = wr_data[3:0];
            m_al = n_al; m_ev = n_ev; m_pend = n_pend;
        end
    end

    function automatic logic [7:0] m_rd(input logic [2:0] s);
        if (s < 6) return m_alm[s];
        if (s == 6) return {4'h0, m_en};
        return {1'b0, m_al, m_ev, 2'b00};
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (irq !== ((m_al && m_en[3]) || m_pend)) begin
                fails++;
                $display("FAIL R9 cycle irq actual=%0b expected=%0b", irq, (m_al && m_en[3]) || m_pend);
            end
            tests++;
            if (rd_data !== m_rd(rd_sel)) begin
                fails++;
                $display("FAIL R2 cycle rd_data sel=%0d actual=%h expected=%h", rd_sel, rd_data, m_rd(rd_sel));
            end
        end
    end

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic upd(input logic [47:0] t, input logic [3:0] f);
        upd_stb = 1; cur_time = t; inc_flags = f;
        tick();
        upd_stb = 0; inc_flags = 0;
    endtask

    task automatic chk(input logic [2:0] s, input logic [7:0] exp, input string tag);
        rd_sel = s; #0.2;
        tests++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", tag, s, rd_data, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #0.2;
        tests++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
        end
    endtask

    function automatic logic [47:0] tm(input logic [7:0] yr, mo, dy, hr, mi, se);
        return {yr, mo, dy, hr, mi, se};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk(3'd7, 8'h00, "R1 status");
        chk(3'd6, 8'h00, "R1 enable");
        chk(3'd0, 8'h00, "R1 alarm");
        chk_irq(1'b0, "R1");

        // alarm 2024-06-15 12:30:45 PM
        wr(3'd0, 8'h45); wr(3'd1, 8'h30); wr(3'd2, 8'h92);
        wr(3'd3, 8'h15); wr(3'd4, 8'h06); wr(3'd5, 8'h24);
        chk(3'd2, 8'h92, "R2 hour");
        chk(3'd5, 8'h24, "R2 year");

        upd(tm(8'h24, 8'h06, 8'h15, 8'h12, 8'h30, 8'h45), 4'b0001);
        chk(3'd7, 8'h00, "R3 meridiem mismatch");
        upd(tm(8'h24, 8'h06, 8'h15, 8'h92, 8'h30, 8'h45), 4'b0001);
        chk(3'd7, 8'h40, "R3 match");
        chk_irq(1'b0, "R9 alarm disabled");
        wr(3'd6, 8'h08);
        chk_irq(1'b1, "R9 alarm enabled");
        chk(3'd6, 8'h08, "R2 enable");

        wr(3'd7, 8'h00);
        chk(3'd7, 8'h40, "R4 write zero");
        wr(3'd7, 8'h3C);
        chk(3'd7, 8'h40, "R4 other bits");
        wr(3'd7, 8'h40);
        chk(3'd7, 8'h00, "R4 clear");
        chk_irq(1'b0, "R4 irq");

        upd(tm(8'h24, 8'h06, 8'h16, 8'h92, 8'h30, 8'h45), 4'b0001);
        chk(3'd7, 8'h00, "R3 day mismatch");

        upd(tm(8'h24, 8'h06, 8'h15, 8'h92, 8'h30, 8'h45), 4'b0001);
        wr_en = 1; wr_sel = 3'd7; wr_data = 8'h40;
        upd(tm(8'h24, 8'h06, 8'h15, 8'h92, 8'h30, 8'h45), 4'b0001);
        wr_en = 0;
        chk(3'd7, 8'h40, "R10 alarm set wins");
        wr(3'd7, 8'h40);
        chk(3'd7, 8'h00, "R4 clear again");

        // periodic, every second
        wr(3'd6, 8'h04);
        upd(tm(8'h24, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01), 4'b0001);
        chk(3'd7, 8'h04, "R5 second event");
        chk_irq(1'b1, "R7 second period");
        wr(3'd7, 8'h04);
        chk_irq(1'b0, "R8 clear selected");
        chk(3'd7, 8'h04, "R5 event persists");
        upd(tm(8'h24, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01), 4'b0000);
        chk(3'd7, 8'h00, "R5 next update");

        // every day, midnight rollover
        wr(3'd6, 8'h07);
        upd(tm(8'h24, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00), 4'b1111);
        chk(3'd7, 8'h3C, "R5 all four");
        chk_irq(1'b1, "R7 day period");
        upd(tm(8'h24, 8'h01, 8'h02, 8'h00, 8'h00, 8'h01), 4'b0001);
        chk(3'd7, 8'h04, "R5 only second");
        chk_irq(1'b1, "R7 still pending");
        wr(3'd7, 8'h04);
        chk_irq(1'b1, "R8 other bit");
        wr(3'd7, 8'h20);
        chk_irq(1'b0, "R8 day bit");

        // every minute
        wr(3'd6, 8'h05);
        upd(tm(8'h24, 8'h01, 8'h02, 8'h00, 8'h00, 8'h02), 4'b0001);
        chk_irq(1'b0, "R7 unselected field");
        chk(3'd7, 8'h04, "R5 regardless of period");
        upd(tm(8'h24, 8'h01, 8'h02, 8'h00, 8'h01, 8'h00), 4'b0011);
        chk(3'd7, 8'h0C, "R5 minute event");
        chk_irq(1'b1, "R7 minute period");
        wr_en = 1; wr_sel = 3'd7; wr_data = 8'h08;
        upd(tm(8'h24, 8'h01, 8'h02, 8'h00, 8'h02, 8'h00), 4'b0011);
        wr_en = 0;
        chk_irq(1'b1, "R10 periodic set wins");
        wr(3'd7, 8'h08);
        chk_irq(1'b0, "R8 minute bit");

        // disable
        upd(tm(8'h24, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00), 4'b1111);
        chk_irq(1'b1, "R7 before disable");
        wr(3'd6, 8'h00);
        tick();
        chk(3'd7, 8'h00, "R6 events cleared");
        chk_irq(1'b0, "R6 pending cleared");
        upd(tm(8'h24, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00), 4'b1111);
        chk(3'd7, 8'h00, "R6 update while off");

        tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule